// File: doc/BRIEF.md
# Looping Single-Bit DRAM Recorder

This block turns a 1-bit-wide dynamic RAM with a multiplexed address bus into a long shift recorder. After reset it stores one sample of a single-bit signal per pacing strobe, filling successive locations. Once every location holds a sample, it switches to playback for good. From then on each strobe reads the next stored bit back onto an audio output, wrapping from the last location to the first until reset.

Each strobe starts a fixed job. First comes a burst of refresh cycles in which the column strobe falls before the row strobe. Then comes one read or write. Every phase of the strobe waveform lasts a parameterised number of clocks, so the timing can meet the DRAM's limits at any clock rate. The linear location is split into a row half and a column half of equal width. The row half counts first, and the column half advances only when the row half wraps.

Top module: `bitloop_dram_ctrl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1 and `addr_oe` and `audio_out` are 0. `addr_oe` is 1 from the first clock edge after reset release. Reset clears the location and the playback flag.
- R2: A high `smp_stb` at a clock edge starts a job only when the block is idle (all strobes high). A strobe seen while a job is running is ignored and does not change the job's waveform.
- R3: A job begins with BURST_LEN refresh cycles. Each cycle holds `cas_n`=0,`ras_n`=1 for T_SET clocks, then both at 0 for T_RAS clocks, then `cas_n`=1,`ras_n`=0 for T_SET clocks, then both at 1 for T_PRE clocks. `we_n` stays 1 throughout.
- R4: The access then drives the row half on `dram_addr` with all strobes high for T_SET clocks. It keeps that address with `ras_n`=0 for T_RAS clocks.
- R5: Next the column half is driven with `ras_n`=0 for T_SET clocks, then with `ras_n`=0 and `cas_n`=0 for T_CAS clocks. In record mode `we_n` is 0 over both of these phases and nowhere else.
- R6: In record mode `dram_d` carries the `sig_in` value sampled at the accepting edge. `audio_out` shows that value from the first precharge clock.
- R7: In playback mode `we_n` stays 1. `dram_q` is sampled in the last clock with `cas_n`=0 and appears on `audio_out` from the first precharge clock.
- R8: After each access the location advances row-first. The row half increments, and when it wraps from all ones to zero the column half increments.
- R9: When the column half also wraps, the block enters playback for good, starting at location zero. Playback repeats the whole recorded sequence indefinitely.
- R10: Each access ends with all strobes high for T_PRE clocks, after which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Pacing strobe, one job per accepted pulse |
| sig_in | input | 1 | Signal bit to record |
| dram_q | input | 1 | DRAM read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_d | output | 1 | DRAM write data |
| addr_oe | output | 1 | Enable for the address and data drivers |
| audio_out | output | 1 | Echoed or replayed bit |

## Verification
The strobe and address pins follow the state register directly. A job accepted at edge k therefore shows its first refresh clock right after edge k. `audio_out` changes at the edge that enters precharge, (T_SET+T_RAS+T_SET+T_PRE)·BURST_LEN + T_SET+T_RAS+T_SET+T_CAS clocks after acceptance. The bench builds the expected waveform for each accepted strobe as a queue of per-clock entries, pops one entry at every falling edge, and compares all outputs there. While the queue is empty it expects the idle pattern. Stray strobes are injected mid-job and leave the queue untouched. Replayed data comes from a behavioural DRAM in the bench, so a wrong address shows up as either an address or a data mismatch.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RF_CAS,
    PH_RF_BOTH,
    PH_RF_RAS,
    PH_RF_PRE,
    PH_AC_ROW,
    PH_AC_RAS,
    PH_AC_COL,
    PH_AC_CAS,
    PH_AC_PRE
  } phase_e;
endpackage

// File: rtl/bl_addr_seq.sv
module bl_addr_seq #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] col,
  output logic             play
);
  localparam logic [ROW_W-1:0] HALF_MAX = {ROW_W{1'b1}};
  localparam logic [ROW_W-1:0] ONE      = ROW_W'(1);

  logic [ROW_W-1:0] row_n, col_n;
  logic             play_n;
  logic             row_wrap, col_wrap;

  assign row_wrap = (row == HALF_MAX);
  assign col_wrap = (col == HALF_MAX);

  always_comb begin
    row_n  = row;
    col_n  = col;
    play_n = play;
    if (step) begin
      row_n = row + ONE;
      if (row_wrap) begin
        col_n = col + ONE;
        if (col_wrap) play_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row  <= '0;
      col  <= '0;
      play <= 1'b0;
    end else if (step) begin
      row  <= row_n;
      col  <= col_n;
      play <= play_n;
    end
  end

  AST_ROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !row_wrap) |=> (col == $past(col))); // R8
  AST_PLAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    play |=> play); // R9
  AST_PLAY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play) |-> (row == '0 && col == '0)); // R9
endmodule

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
  import bl_pkg::*;
#(
  parameter int T_SET     = 1,
  parameter int T_RAS     = 9,
  parameter int T_CAS     = 3,
  parameter int T_PRE     = 7,
  parameter int BURST_LEN = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   step
);
  localparam int MAX_A = (T_SET > T_RAS) ? T_SET : T_RAS;
  localparam int MAX_B = (T_CAS > T_PRE) ? T_CAS : T_PRE;
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_L + 1);
  localparam int BCW   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [TW-1:0]  L_SET  = TW'(T_SET - 1);
  localparam logic [TW-1:0]  L_RAS  = TW'(T_RAS - 1);
  localparam logic [TW-1:0]  L_CAS  = TW'(T_CAS - 1);
  localparam logic [TW-1:0]  L_PRE  = TW'(T_PRE - 1);
  localparam logic [BCW-1:0] BC_END = BCW'(BURST_LEN - 1);

  phase_e          ph_q, ph_n;
  logic [TW-1:0]   tmr_q, tmr_n;
  logic [BCW-1:0]  bc_q, bc_n;
  logic            tmr_done;

  function automatic logic [TW-1:0] load_of(input phase_e p);
    case (p)
      PH_RF_BOTH, PH_AC_RAS: load_of = L_RAS;
      PH_AC_CAS:             load_of = L_CAS;
      PH_RF_PRE, PH_AC_PRE:  load_of = L_PRE;
      default:               load_of = L_SET;
    endcase
  endfunction

  assign tmr_done = (tmr_q == '0);

  always_comb begin
    ph_n  = ph_q;
    tmr_n = tmr_q;
    bc_n  = bc_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_n  = PH_RF_CAS;
        tmr_n = L_SET;
        bc_n  = '0;
      end
    end else if (!tmr_done) begin
      tmr_n = tmr_q - TW'(1);
    end else begin
      case (ph_q)
        PH_RF_CAS:  ph_n = PH_RF_BOTH;
        PH_RF_BOTH: ph_n = PH_RF_RAS;
        PH_RF_RAS:  ph_n = PH_RF_PRE;
        PH_RF_PRE: begin
          if (bc_q == BC_END) ph_n = PH_AC_ROW;
          else begin
            ph_n = PH_RF_CAS;
            bc_n = bc_q + BCW'(1);
          end
        end
        PH_AC_ROW:  ph_n = PH_AC_RAS;
        PH_AC_RAS:  ph_n = PH_AC_COL;
        PH_AC_COL:  ph_n = PH_AC_CAS;
        PH_AC_CAS:  ph_n = PH_AC_PRE;
        default:    ph_n = PH_IDLE;
      endcase
      tmr_n = load_of(ph_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
      bc_q  <= '0;
    end else begin
      ph_q  <= ph_n;
      tmr_q <= tmr_n;
      bc_q  <= bc_n;
    end
  end

  assign phase = ph_q;
  assign step  = (ph_q == PH_AC_CAS) && tmr_done;

  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && start) |=> (ph_q == PH_RF_CAS)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_AC_CAS && !tmr_done) |=> (ph_q == PH_AC_CAS)); // R2
  AST_PRE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_AC_PRE && tmr_done) |=> (ph_q == PH_IDLE)); // R10
endmodule

// File: rtl/bitloop_dram_ctrl.sv
module bitloop_dram_ctrl
  import bl_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int T_SET     = 1,
  parameter int T_RAS     = 9,
  parameter int T_CAS     = 3,
  parameter int T_PRE     = 7,
  parameter int BURST_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             sig_in,
  input  logic             dram_q,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] dram_addr,
  output logic             dram_d,
  output logic             addr_oe,
  output logic             audio_out
);
  phase_e           phase;
  logic             step, play, accept;
  logic [ROW_W-1:0] row, col;
  logic             smp_q, smp_n, aud_q, aud_n;
  logic             ras_on, cas_on, col_sel;

  bl_seq_fsm #(
    .T_SET(T_SET), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE),
    .BURST_LEN(BURST_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(smp_stb), .phase(phase), .step(step)
  );

  bl_addr_seq #(.ROW_W(ROW_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .step(step), .row(row), .col(col), .play(play)
  );

  assign accept  = (phase == PH_IDLE) && smp_stb;
  assign col_sel = (phase == PH_AC_COL) || (phase == PH_AC_CAS);
  assign ras_on  = (phase == PH_RF_BOTH) || (phase == PH_RF_RAS) ||
                   (phase == PH_AC_RAS)  || col_sel;
  assign cas_on  = (phase == PH_RF_CAS) || (phase == PH_RF_BOTH) ||
                   (phase == PH_AC_CAS);

  always_comb begin
    smp_n = smp_q;
    aud_n = aud_q;
    if (accept) smp_n = sig_in;
    if (step)   aud_n = play ? dram_q : smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b0;
      aud_q   <= 1'b0;
      addr_oe <= 1'b0;
    end else begin
      addr_oe <= 1'b1;
      if (accept) smp_q <= smp_n;
      if (step)   aud_q <= aud_n;
    end
  end

  assign ras_n     = ~(ras_on & addr_oe);
  assign cas_n     = ~(cas_on & addr_oe);
  assign we_n      = ~(col_sel & ~play & addr_oe);
  assign dram_addr = col_sel ? col : row;
  assign dram_d    = smp_q;
  assign audio_out = aud_q;

  AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (ras_n && cas_n && we_n)); // R1
  AST_WE_IN_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ras_n); // R5
  AST_NO_WRITE_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    play |-> we_n); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dram_d)); // R6
  AST_COL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !ras_n && $past(!ras_n && !cas_n)) |-> $stable(dram_addr)); // R5
endmodule

// File: tb/bitloop_dram_ctrl_tb_top.sv
module bitloop_dram_ctrl_tb_top;
  localparam int W   = 2;
  localparam int TS  = 1;
  localparam int TR  = 2;
  localparam int TC  = 2;
  localparam int TP  = 2;
  localparam int BL  = 2;
  localparam int LOCS  = 1 << (2 * W);
  localparam int TOTAL = LOCS + 36;

  typedef struct packed {
    logic         ras;
    logic         cas;
    logic         we;
    logic         ca;
    logic [W-1:0] a;
    logic         sa;
    logic         au;
  } ent_t;

  logic clk, rst_n, smp_stb, sig_in, dram_q;
  logic ras_n, cas_n, we_n, dram_d, addr_oe, audio_out;
  logic [W-1:0] dram_addr;

  bitloop_dram_ctrl #(
    .ROW_W(W), .T_SET(TS), .T_RAS(TR), .T_CAS(TC), .T_PRE(TP), .BURST_LEN(BL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .sig_in(sig_in),
    .dram_q(dram_q), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_addr(dram_addr), .dram_d(dram_d), .addr_oe(addr_oe),
    .audio_out(audio_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural 1-bit DRAM
  logic         mem [LOCS];
  logic [W-1:0] lat_row, lat_col;
  initial begin
    lat_row = '0;
    lat_col = '0;
    for (int i = 0; i < LOCS; i++) mem[i] = 1'b0;
  end
  always @(negedge ras_n) if (cas_n) lat_row = dram_addr;
  always @(negedge cas_n) if (!ras_n) begin
    lat_col = dram_addr;
    if (!we_n) mem[{lat_col, lat_row}] = dram_d;
  end
  assign dram_q = (!ras_n && !cas_n) ? mem[{lat_col, lat_row}] : 1'b0;

  int    checks, fails;
  ent_t  exp_q[$];
  string tag_q[$];
  logic  rec_bits [LOCS];
  int    m_idx;
  logic  m_play, cur_aud;

  task automatic chk(input logic ok, input string tag, input string what,
                     input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, expv);
    end
  endtask

  task automatic add(input logic r, input logic c, input logic w, input logic ca,
                     input logic [W-1:0] a, input logic sa, input logic au,
                     input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{r, c, w, ca, a, sa, au});
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_job(input logic bit_in);
    logic [W-1:0] r, c;
    logic         aud;
    r = W'(m_idx % (1 << W));
    c = W'(m_idx / (1 << W));
    for (int b = 0; b < BL; b++) begin
      add(1, 0, 1, 0, '0, 0, 0, "R3", TS);
      add(0, 0, 1, 0, '0, 0, 0, "R3", TR);
      add(0, 1, 1, 0, '0, 0, 0, "R3", TS);
      add(1, 1, 1, 0, '0, 0, 0, "R3", TP);
    end
    add(1, 1, 1, 1, r, 0, 0, "R4", TS);
    add(0, 1, 1, 1, r, 0, 0, "R4", TR);
    add(0, 1, m_play, 1, c, 0, 0, "R5", TS);
    add(0, 0, m_play, 1, c, 0, 0, "R5", TC);
    if (!m_play) begin
      rec_bits[m_idx] = bit_in;
      aud = bit_in;
      add(1, 1, 1, 0, '0, 1, aud, "R6", 1);
    end else begin
      aud = rec_bits[m_idx];
      add(1, 1, 1, 0, '0, 1, aud, "R7,R9", 1);
    end
    add(1, 1, 1, 0, '0, 0, 0, "R10", TP - 1);
    m_idx++;
    if (m_idx == LOCS) begin
      m_idx  = 0;
      m_play = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    int acc, cyc, gap;
    logic was_idle;
    ent_t e;
    string t;
    checks = 0; fails = 0;
    m_idx = 0; m_play = 1'b0; cur_aud = 1'b0;
    lfsr = 8'h5b; acc = 0; cyc = 0; gap = 1;
    rst_n = 1'b0; smp_stb = 1'b0; sig_in = 1'b0;
    for (int i = 0; i < LOCS; i++) rec_bits[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && we_n, "R1", "strobes", {ras_n, cas_n, we_n}, 7);
    chk(!addr_oe, "R1", "addr_oe", addr_oe, 0);
    chk(!audio_out, "R1", "audio", audio_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_oe, "R1", "addr_oe after release", addr_oe, 1);
    while ((acc < TOTAL || exp_q.size() != 0) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      smp_stb = 1'b0;
      was_idle = (exp_q.size() == 0);
      if (was_idle) begin
        e = '{1, 1, 1, 0, '0, 0, 0};
        t = "R2";
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end
      if (e.sa) cur_aud = e.au;
      chk({ras_n, cas_n, we_n} == {e.ras, e.cas, e.we}, t, "ras/cas/we",
          {ras_n, cas_n, we_n}, {e.ras, e.cas, e.we});
      if (e.ca)
        chk(dram_addr == e.a, "R8", "address", dram_addr, e.a);
      chk(audio_out == cur_aud, t, "audio", audio_out, cur_aud);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (was_idle) begin
        if (gap == 0 && acc < TOTAL) begin
          smp_stb = 1'b1;
          sig_in  = lfsr[0];
          push_job(lfsr[0]);
          acc++;
          gap = acc % 3;
        end else if (gap > 0) begin
          gap--;
        end
      end else if (cyc % 7 == 3) begin
        // R2: stray strobe mid-job, must be ignored
        smp_stb = 1'b1;
        sig_in  = lfsr[1];
      end
    end
    if (cyc >= 150000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog got %0d exp %0d", cyc, 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule